// File: doc/BRIEF.md
# Periodic Down-Counting System Tick Timer

This block is a reloadable down-counter that produces a periodic tick for an interrupt controller. Software programs a 24-bit reload value and then enables the counter. The counter takes the reload value and decrements on every tick. A tick is either every clock cycle or every cycle in which the reference tick enable is high, and a control bit selects between the two. When the count steps from one to zero, a sticky flag is set. If interrupts are enabled, a one-cycle request pulse goes to the interrupt controller. On the next tick the counter takes the reload value again.

The block is reached through a plain single-cycle register port with a write strobe, a read strobe, a byte offset and 32-bit data. Read data is combinational in the cycle of the read strobe, and the side effects of the access take place at the clock edge that ends that cycle. No data stream passes through the block, so it has no valid/ready handshake. Each access takes exactly one cycle and cannot be held off. Write and read strobes are not raised in the same cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset every register bit and `tick_irq` are 0. The control register at offset 0x10 holds run at bit 0, irq-enable at bit 1 and source at bit 2, where source=1 counts every clock cycle and source=0 counts only cycles with `ref_tick` high. A write changes only bits [2:0], and the other written bits are ignored.
- R2: A read of 0x10 returns the wrap flag in bit 16 and clears it at that clock edge, unless the count reaches zero in the same cycle, in which case the flag stays set.
- R3: Writing 1 to run when it was 0 loads the counter from the reload register (0x14). The counter then decrements once per tick and takes the reload value on the tick after zero, so each period lasts reload+1 ticks. Offset 0x18 reads the count.
- R4: A tick that moves the count from 1 to 0 sets the wrap flag. If irq-enable is 1, `tick_irq` is high for exactly the following cycle.
- R5: Any write to 0x18 clears the wrap flag and, while running, reloads the counter whatever the data.
- R6: Offset 0x18 reads 0 while run is 0.
- R7: A control write that changes the source bit while run stays 1 reloads the counter.
- R8: With a reload value of 0 the running count stays at 0, and neither the flag nor `tick_irq` is ever raised.
- R9: The reload and count registers are 24 bits wide and their upper 8 bits read 0. Offset 0x1C reads the calibration parameter in bits [23:0]. Other offsets read 0.
- R10: With source=0 the count does not move in cycles where `ref_tick` is 0.
- R11: In a cycle that writes 0x10 or 0x18 the counter does not take a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference tick enable (used when source=0) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| tick_irq | output | 1 | One-cycle tick interrupt request |

## Verification
The hardest case to reach is the collision of register accesses with the cycle in which the count steps from 1 to 0. Examples are a flag-clearing read in that exact cycle, or a control or count write that has to suppress the tick. Directed phases alone seldom land on it. After the directed phases, a long stretch of short reload values and randomly mixed accesses and reference ticks makes such coincidences frequent. A behavioural model tracks the expected flag, count and request on every cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int OFF_W = 8;
  localparam logic [OFF_W-1:0] OFF_CTRL = 8'h10;
  localparam logic [OFF_W-1:0] OFF_LOAD = 8'h14;
  localparam logic [OFF_W-1:0] OFF_CURR = 8'h18;
  localparam logic [OFF_W-1:0] OFF_CALB = 8'h1C;
  localparam int BIT_RUN  = 0;
  localparam int BIT_IEN  = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;

  typedef struct packed {
    logic src;
    logic ien;
    logic run;
  } ctl_t;
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cur_val,
  output logic             zero_hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (load) begin
      cur_q <= reload_val;
    end else if (tick_en) begin
      if (cur_q == '0) cur_q <= reload_val;
      else             cur_q <= cur_q - ONE;
    end
  end

  assign cur_val  = cur_q;
  assign zero_hit = tick_en && !load && (cur_q == ONE);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load) |=> $stable(cur_q));
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_q == $past(reload_val)));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load && cur_q != '0) |=> (cur_q == $past(cur_q) - ONE));
  assert_zero_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load && cur_q == '0 && reload_val == '0) |=> (cur_q == '0));
endmodule

// File: rtl/tick_csr.sv
module tick_csr
  import tick_timer_pkg::*;
#(
  parameter int               ADDR_W  = 8,
  parameter int               CNT_W   = 24,
  parameter logic [CNT_W-1:0] CAL_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [CNT_W-1:0]  cur_val,
  input  logic              zero_hit,
  output logic [31:0]       bus_rdata,
  output logic [CNT_W-1:0]  reload_val,
  output logic              tick_en,
  output logic              load,
  output logic              tick_irq
);
  localparam int PAD_W = 32 - CNT_W;

  ctl_t             ctl_q;
  logic             flag_q;
  logic [CNT_W-1:0] reload_q;
  logic             irq_q;

  logic sel_ctrl, sel_load, sel_curr, sel_calb;
  logic wr_ctrl, wr_load, wr_curr, rd_ctrl;
  logic src_change;

  assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
  assign sel_load = (bus_addr == ADDR_W'(OFF_LOAD));
  assign sel_curr = (bus_addr == ADDR_W'(OFF_CURR));
  assign sel_calb = (bus_addr == ADDR_W'(OFF_CALB));

  assign wr_ctrl = bus_wr && sel_ctrl;
  assign wr_load = bus_wr && sel_load;
  assign wr_curr = bus_wr && sel_curr;
  assign rd_ctrl = bus_rd && sel_ctrl;

  assign src_change = (bus_wdata[BIT_SRC] != ctl_q.src);

  // Register writes take priority over the tick in their cycle.
  assign tick_en = ctl_q.run && (ctl_q.src || ref_tick) && !wr_ctrl && !wr_curr;
  assign load    = (wr_ctrl && bus_wdata[BIT_RUN] && (!ctl_q.run || src_change))
                || (wr_curr && ctl_q.run);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      flag_q   <= 1'b0;
      reload_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= zero_hit && ctl_q.ien;
      if (wr_ctrl) begin
        ctl_q.run <= bus_wdata[BIT_RUN];
        ctl_q.ien <= bus_wdata[BIT_IEN];
        ctl_q.src <= bus_wdata[BIT_SRC];
      end
      if (wr_load) reload_q <= bus_wdata[CNT_W-1:0];
      if (zero_hit)                flag_q <= 1'b1;
      else if (rd_ctrl || wr_curr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_ctrl) begin
        bus_rdata[BIT_RUN]  = ctl_q.run;
        bus_rdata[BIT_IEN]  = ctl_q.ien;
        bus_rdata[BIT_SRC]  = ctl_q.src;
        bus_rdata[BIT_FLAG] = flag_q;
      end else if (sel_load) begin
        bus_rdata = {{PAD_W{1'b0}}, reload_q};
      end else if (sel_curr) begin
        bus_rdata = ctl_q.run ? {{PAD_W{1'b0}}, cur_val} : '0;
      end else if (sel_calb) begin
        bus_rdata = {{PAD_W{1'b0}}, CAL_VAL};
      end
    end
  end

  assign reload_val = reload_q;
  assign tick_irq   = irq_q;

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> flag_q);
  assert_rd_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !zero_hit) |=> !flag_q);
  assert_curr_wr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_curr |=> !flag_q);
  assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq);
  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> $past(ctl_q.ien));
  assert_no_tick_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl || wr_curr) |-> !tick_en);
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int               ADDR_W  = 8,
  parameter int               CNT_W   = 24,
  parameter logic [CNT_W-1:0] CAL_VAL = 24'h0F423F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tick_irq
);
  logic [CNT_W-1:0] cur_val;
  logic [CNT_W-1:0] reload_val;
  logic             tick_en;
  logic             load;
  logic             zero_hit;

  tick_csr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CAL_VAL(CAL_VAL)) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick   (ref_tick),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cur_val    (cur_val),
    .zero_hit   (zero_hit),
    .bus_rdata  (bus_rdata),
    .reload_val (reload_val),
    .tick_en    (tick_en),
    .load       (load),
    .tick_irq   (tick_irq)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .load       (load),
    .reload_val (reload_val),
    .cur_val    (cur_val),
    .zero_hit   (zero_hit)
  );
endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  localparam logic [23:0] CAL = 24'h0F423F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference state
  bit m_run, m_ien, m_src, m_flag, m_irq;
  int unsigned m_rel, m_cur;

  always #2.5 clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_irq(tick_irq)
  );

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h10: return {15'd0, m_flag, 13'd0, m_src, m_ien, m_run};
      8'h14: return m_rel;
      8'h18: return m_run ? m_cur : 0;
      8'h1C: return {8'd0, CAL};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h10: return "R2";
      8'h18: return "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic mstep(input logic wr, input logic rd, input logic [7:0] a,
                       input logic [31:0] d, input logic rt);
    bit wc, wl, wu, tk, fire;
    wc = wr && a == 8'h10;
    wl = wr && a == 8'h14;
    wu = wr && a == 8'h18;
    tk = m_run && (m_src || rt) && !wc && !wu;
    fire = tk && m_cur == 1;
    m_irq = fire && m_ien;
    if (rd && a == 8'h10) m_flag = 0;
    if (wu) m_flag = 0;
    if (fire) m_flag = 1;
    if (wc) begin
      if (d[0] && (!m_run || d[2] != m_src)) m_cur = m_rel;
      m_run = d[0]; m_ien = d[1]; m_src = d[2];
    end else if (wu) begin
      if (m_run) m_cur = m_rel;
    end else if (tk) begin
      m_cur = (m_cur == 0) ? m_rel : m_cur - 1;
    end
    if (wl) m_rel = d[23:0];
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [7:0] a,
                     input logic [31:0] d, input logic rt, input string tag);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; ref_tick = rt;
    #1;
    if (rd) chk(bus_rdata, mread(a), tag);
    chk({31'd0, tick_irq}, {31'd0, m_irq}, "R4 irq");
    @(posedge clk);
    mstep(wr, rd, a, d, rt);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d, input logic rt = 1'b0);
    cyc(1'b1, 1'b0, a, d, rt, "wr");
  endtask

  task automatic rreg(input logic [7:0] a, input string tag, input logic rt = 1'b0);
    cyc(1'b0, 1'b1, a, 32'd0, rt, tag);
  endtask

  task automatic run_cur(input int n, input string tag, input bit rt_every = 1);
    for (int i = 0; i < n; i++) rreg(8'h18, tag, rt_every);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    rreg(8'h10, "R1 ctrl reset");
    rreg(8'h14, "R1 reload reset");
    rreg(8'h18, "R1 curr reset");
    rreg(8'h1C, "R9 calibration");
    rreg(8'h2C, "R9 unmapped");
    // R9 width, R1 write mask
    wreg(8'h14, 32'hFFFF_FFFF);
    rreg(8'h14, "R9 reload upper zero");
    wreg(8'h10, 32'hFFFF_FFF0);
    rreg(8'h10, "R1 upper ctrl bits ignored");
    // R6 disabled reads zero
    rreg(8'h18, "R6 disabled curr");
    // R3/R4 processor clock, irq enabled, reload 5
    wreg(8'h14, 32'd5);
    wreg(8'h10, 32'h7);
    run_cur(20, "R3 count");
    rreg(8'h10, "R2 flag set read");
    rreg(8'h10, "R2 flag cleared");
    // R5 / R11 current write mid count
    run_cur(2, "R3");
    wreg(8'h18, 32'hDEAD);
    rreg(8'h18, "R5 R11 reloaded");
    rreg(8'h10, "R5 flag cleared");
    // R7 / R10 switch to reference tick
    run_cur(3, "R3");
    wreg(8'h10, 32'h3);
    run_cur(6, "R10 no ref tick", 1'b0);
    for (int i = 0; i < 30; i++) rreg(8'h18, "R10 ref ticks", (i % 3) == 0);
    wreg(8'h10, 32'h7);
    rreg(8'h18, "R7 src change reload");
    // R6 disable
    wreg(8'h10, 32'h0);
    rreg(8'h18, "R6 disabled curr");
    // R8 reload zero
    wreg(8'h10, 32'h0);
    rreg(8'h10, "R2");
    wreg(8'h14, 32'd0);
    wreg(8'h10, 32'h7);
    run_cur(20, "R8 stays zero");
    rreg(8'h10, "R8 no flag");
    // irq disabled: flag without request
    wreg(8'h14, 32'd2);
    wreg(8'h10, 32'h5);
    run_cur(10, "R4 no irq when disabled");
    rreg(8'h10, "R4 flag without irq");
    // random mixing
    for (int i = 0; i < 6000; i++) begin
      int op;
      logic rt;
      op = $urandom_range(0, 19);
      rt = $urandom_range(0, 1);
      case (op)
        0: wreg(8'h10, $urandom(), rt);
        1: wreg(8'h14, $urandom_range(0, 6), rt);
        2: wreg(8'h18, $urandom(), rt);
        3, 4, 5: rreg(8'h10, "R2 random", rt);
        6: rreg(8'h14, "R9 random", rt);
        7: cyc(1'b0, 1'b0, 8'h00, 32'd0, rt, "idle");
        default: rreg(8'h18, "R3 random", rt);
      endcase
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule